// File: doc/BRIEF.md
# Main Clock Failure Detector

This block watches a main clock from an always-running reference clock. The main clock flips a flag on every rising edge. The flag is carried into the reference domain through a short flop chain. If no flip arrives for a programmable number of reference cycles, the main clock is declared dead.

When detection is armed and the main clock is the selected CPU clock, a dead main clock triggers a failover. In one reference cycle the block switches the CPU clock selection to an on-chip oscillator, forces the low-speed on-chip oscillator on, latches a sticky stopped flag and raises a level interrupt together with a cause flag. The interrupt line is shared with a watchdog, and the cause flag tells the two apart. A fallback select bit chooses whether the on-chip source is the low-speed or the high-speed oscillator.

The block never returns to the main clock on its own. Software must write a return request, and that request is accepted only once the main clock is toggling again. The glitch-free clock multiplexer, the oscillators and the interrupt controller are outside this block; it only drives their select and enable signals. Detection is not dependable for main clocks below about 2 MHz, and software should keep the block disarmed in that case.

Top module: `clk_fail_detect`

## Requirements
- R1: Failover happens only while the registered arm field equals binary 11. The code 00 and the other codes (01, 10) never switch the source, even with a dead main clock. Writing 11 while the main clock is already dead causes failover.
- R2: While armed and while `src_onchip` is 0 (main clock selected), a dead main clock sets `src_onchip` to 1.
- R3: `stop_flag` is set by failover and stays set until a write with `cfg_clr_stop`=1. A write that clears only the interrupt leaves it set.
- R4: `losc_on` becomes 1 at failover. It returns to 0 only when a return request is accepted.
- R5: `irq` and `irq_cause_clk` both become 1 at failover. Both stay 1 until a write with `cfg_clr_irq`=1.
- R6: `src_onchip` never falls because the main clock restarts. It falls only on a write with `cfg_ret_main`=1 while the main clock is toggling. A return request made while the main clock is still dead is ignored.
- R7: `src_hs` shows the fallback select written through `cfg_fb_hs` (0 = low-speed, 1 = high-speed). It resets to 0.
- R8: While `src_onchip` is 1, a main clock that stays dead raises no new interrupt and does not set `stop_flag` again after software clears them.
- R9: A main clock whose edges come closer together than `TIMEOUT_CYC` reference cycles (default 16) never triggers failover.
- R10: If failover and a write with `cfg_clr_irq` or `cfg_clr_stop` fall in the same cycle, failover wins and the flags are set.
- R11: Reset clears every output to 0 and returns the arm field to 00. After reset, a dead main clock is therefore not acted on until software arms the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Always-running reference clock; all control and status logic runs on it |
| rst | input | 1 | Synchronous active-high reset, reference domain |
| clk_main | input | 1 | Main clock being monitored |
| cfg_we | input | 1 | Control write strobe, one reference cycle per write |
| cfg_arm | input | 2 | Arm field; 11 arms detection, every other code disarms it |
| cfg_fb_hs | input | 1 | Fallback oscillator select; 0 low-speed, 1 high-speed |
| cfg_ret_main | input | 1 | Action bit: request return to the main clock |
| cfg_clr_stop | input | 1 | Action bit: write-one-to-clear for the stopped flag |
| cfg_clr_irq | input | 1 | Action bit: write-one-to-clear for the interrupt and cause |
| src_onchip | output | 1 | CPU clock select; 1 means on-chip oscillator |
| src_hs | output | 1 | Chosen on-chip oscillator; 1 means high-speed |
| stop_flag | output | 1 | Sticky main-clock-stopped status |
| losc_on | output | 1 | Forced enable for the low-speed on-chip oscillator |
| irq | output | 1 | Level interrupt request |
| irq_cause_clk | output | 1 | Cause flag marking the request as a clock stop |

## Verification
The failover event and a software write that clears the interrupt or the stopped flag can land in the same reference cycle. No outside observer can predict the exact detection cycle, so the bench holds the write strobe high with the clear-interrupt bit set for every cycle while the main clock is stopped. The bench then counts the sampled cycles in which `irq` is high. If failover wins, that count is exactly one and the stopped flag, which the writes leave alone, stays set. If the clear wins, `irq` is never seen high.

// File: rtl/cfd_pkg.sv
package cfd_pkg;
  // Arm field code that enables detection; every other code leaves it off.
  localparam logic [1:0] ARM_ON  = 2'b11;
  localparam logic [1:0] ARM_OFF = 2'b00;

  typedef enum logic {
    FB_LOW  = 1'b0,
    FB_HIGH = 1'b1
  } fallback_e;

  typedef struct packed {
    logic [1:0] arm;
    fallback_e  fb;
  } ctrl_t;
endpackage

// File: rtl/cfd_toggle.sv
// Main-domain activity flag: flips on every main clock edge.
module cfd_toggle (
  input  logic clk_main,
  output logic tgl_o
);
  logic tgl_q = 1'b0;

  always_ff @(posedge clk_main) begin
    tgl_q <= ~tgl_q;
  end

  assign tgl_o = tgl_q;
endmodule

// File: rtl/cfd_sync.sv
// Flop chain that carries the activity flag into the reference domain.
module cfd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) ff_q <= '0;
        else     ff_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) ff_q <= '0;
        else     ff_q <= {ff_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/cfd_timeout.sv
// Counts reference cycles since the last seen flip; saturates at LIMIT.
module cfd_timeout #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_i,
  output logic dead_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

  logic          last_q;
  logic [CW-1:0] cnt_q;
  logic          flip;

  assign flip = last_q ^ sync_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      last_q <= sync_i;
      if (flip)               cnt_q <= '0;
      else if (cnt_q != LIM_V) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign dead_o = (cnt_q == LIM_V);
endmodule

// File: rtl/cfd_ctrl.sv
// Control register, failover decision and status flags.
module cfd_ctrl
  import cfd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       we_i,
  input  ctrl_t      wdata_i,
  input  logic       ret_i,
  input  logic       clr_stop_i,
  input  logic       clr_irq_i,
  input  logic       dead_i,
  output logic [1:0] arm_o,
  output logic       sel_o,
  output logic       hs_o,
  output logic       stop_o,
  output logic       lso_o,
  output logic       irq_o,
  output logic       cause_o
);
  ctrl_t ctrl_q;
  logic  sel_q, stop_q, lso_q, irq_q, cause_q;
  logic  armed, fail_evt, ret_ok;

  assign armed    = (ctrl_q.arm == ARM_ON);
  assign fail_evt = armed && !sel_q && dead_i;
  assign ret_ok   = we_i && ret_i && sel_q && !dead_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '{arm: ARM_OFF, fb: FB_LOW};
      sel_q   <= 1'b0;
      stop_q  <= 1'b0;
      lso_q   <= 1'b0;
      irq_q   <= 1'b0;
      cause_q <= 1'b0;
    end else begin
      if (we_i) ctrl_q <= wdata_i;
      if (fail_evt) begin
        // failover outranks any clear written in the same cycle
        sel_q   <= 1'b1;
        stop_q  <= 1'b1;
        lso_q   <= 1'b1;
        irq_q   <= 1'b1;
        cause_q <= 1'b1;
      end else begin
        if (ret_ok) begin
          sel_q <= 1'b0;
          lso_q <= 1'b0;
        end
        if (we_i && clr_stop_i) stop_q <= 1'b0;
        if (we_i && clr_irq_i) begin
          irq_q   <= 1'b0;
          cause_q <= 1'b0;
        end
      end
    end
  end

  assign arm_o   = ctrl_q.arm;
  assign hs_o    = ctrl_q.fb;
  assign sel_o   = sel_q;
  assign stop_o  = stop_q;
  assign lso_o   = lso_q;
  assign irq_o   = irq_q;
  assign cause_o = cause_q;
endmodule

// File: rtl/clk_fail_detect.sv
module clk_fail_detect
  import cfd_pkg::*;
#(
  parameter int TIMEOUT_CYC = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_ref,
  input  logic       rst,
  input  logic       clk_main,
  input  logic       cfg_we,
  input  logic [1:0] cfg_arm,
  input  logic       cfg_fb_hs,
  input  logic       cfg_ret_main,
  input  logic       cfg_clr_stop,
  input  logic       cfg_clr_irq,
  output logic       src_onchip,
  output logic       src_hs,
  output logic       stop_flag,
  output logic       losc_on,
  output logic       irq,
  output logic       irq_cause_clk
);
  logic       tgl_main;
  logic       tgl_ref;
  logic       dead;
  logic [1:0] arm_q;
  ctrl_t      wdata;

  assign wdata = '{arm: cfg_arm, fb: fallback_e'(cfg_fb_hs)};

  cfd_toggle u_tgl (
    .clk_main (clk_main),
    .tgl_o    (tgl_main)
  );

  cfd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk_ref),
    .rst (rst),
    .d_i (tgl_main),
    .q_o (tgl_ref)
  );

  cfd_timeout #(.LIMIT(TIMEOUT_CYC)) u_tmo (
    .clk    (clk_ref),
    .rst    (rst),
    .sync_i (tgl_ref),
    .dead_o (dead)
  );

  cfd_ctrl u_ctrl (
    .clk        (clk_ref),
    .rst        (rst),
    .we_i       (cfg_we),
    .wdata_i    (wdata),
    .ret_i      (cfg_ret_main),
    .clr_stop_i (cfg_clr_stop),
    .clr_irq_i  (cfg_clr_irq),
    .dead_i     (dead),
    .arm_o      (arm_q),
    .sel_o      (src_onchip),
    .hs_o       (src_hs),
    .stop_o     (stop_flag),
    .lso_o      (losc_on),
    .irq_o      (irq),
    .cause_o    (irq_cause_clk)
  );
endmodule

// File: rtl/clk_fail_detect_chk.sv
module clk_fail_detect_chk (
  input logic       clk_ref,
  input logic       rst,
  input logic       cfg_we,
  input logic       cfg_ret_main,
  input logic       cfg_clr_stop,
  input logic       cfg_clr_irq,
  input logic [1:0] arm_q,
  input logic       dead,
  input logic       src_onchip,
  input logic       stop_flag,
  input logic       losc_on,
  input logic       irq,
  input logic       irq_cause_clk
);
  // R1
  arm_only_chk: assert property (@(posedge clk_ref) disable iff (rst)
    $rose(src_onchip) |-> $past(arm_q == 2'b11));

  // R2
  failover_all_chk: assert property (@(posedge clk_ref) disable iff (rst)
    $rose(src_onchip) |-> (stop_flag && losc_on && irq && irq_cause_clk));

  // R3
  stop_sticky_chk: assert property (@(posedge clk_ref) disable iff (rst)
    $fell(stop_flag) |-> $past(cfg_we && cfg_clr_stop));

  // R5
  irq_hold_chk: assert property (@(posedge clk_ref) disable iff (rst)
    $fell(irq) |-> $past(cfg_we && cfg_clr_irq));

  // R5
  cause_pair_chk: assert property (@(posedge clk_ref) disable iff (rst)
    irq |-> irq_cause_clk);

  // R4
  losc_release_chk: assert property (@(posedge clk_ref) disable iff (rst)
    $fell(losc_on) |-> $past(cfg_we && cfg_ret_main));

  // R6
  no_auto_return_chk: assert property (@(posedge clk_ref) disable iff (rst)
    $fell(src_onchip) |-> $past(cfg_we && cfg_ret_main && !dead));

  // R8
  single_event_chk: assert property (@(posedge clk_ref) disable iff (rst)
    $rose(irq) |-> $rose(src_onchip));

  // R11
  reset_state_chk: assert property (@(posedge clk_ref)
    rst |=> (!src_onchip && !stop_flag && !losc_on && !irq && !irq_cause_clk));
endmodule

bind clk_fail_detect clk_fail_detect_chk u_chk (
  .clk_ref       (clk_ref),
  .rst           (rst),
  .cfg_we        (cfg_we),
  .cfg_ret_main  (cfg_ret_main),
  .cfg_clr_stop  (cfg_clr_stop),
  .cfg_clr_irq   (cfg_clr_irq),
  .arm_q         (arm_q),
  .dead          (dead),
  .src_onchip    (src_onchip),
  .stop_flag     (stop_flag),
  .losc_on       (losc_on),
  .irq           (irq),
  .irq_cause_clk (irq_cause_clk)
);

// File: tb/test_clk_fail_detect.sv
`timescale 1ns/1ps
module test_clk_fail_detect;
  logic       clk_ref = 1'b0;
  logic       clk_main = 1'b0;
  logic       main_run = 1'b1;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_arm = 2'b00;
  logic       cfg_fb_hs = 1'b0;
  logic       cfg_ret_main = 1'b0;
  logic       cfg_clr_stop = 1'b0;
  logic       cfg_clr_irq = 1'b0;
  logic       src_onchip, src_hs, stop_flag, losc_on, irq, irq_cause_clk;

  int ntests = 0;
  int nfail = 0;
  int irq_hi = 0;
  logic win_on = 1'b0;

  string      rid_q[$];
  logic [5:0] exp_q[$];

  always #2 clk_ref = ~clk_ref;
  always #5 if (main_run) clk_main = ~clk_main;

  clk_fail_detect i_clk_fail_detect (
    .clk_ref(clk_ref), .rst(rst), .clk_main(clk_main),
    .cfg_we(cfg_we), .cfg_arm(cfg_arm), .cfg_fb_hs(cfg_fb_hs),
    .cfg_ret_main(cfg_ret_main), .cfg_clr_stop(cfg_clr_stop),
    .cfg_clr_irq(cfg_clr_irq), .src_onchip(src_onchip), .src_hs(src_hs),
    .stop_flag(stop_flag), .losc_on(losc_on), .irq(irq),
    .irq_cause_clk(irq_cause_clk)
  );

  // monitor: pops one expected item per falling edge and compares
  always @(negedge clk_ref) begin
    if (win_on && irq) irq_hi++;
    if (exp_q.size() > 0) begin
      logic [5:0] e, a;
      string r;
      e = exp_q.pop_front();
      r = rid_q.pop_front();
      a = {src_onchip, src_hs, stop_flag, losc_on, irq, irq_cause_clk};
      ntests++;
      if (a !== e) begin
        nfail++;
        $display("FAIL %s sel/hs/stop/losc/irq/cause act=%b exp=%b", r, a, e);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk_ref);
    #1;
  endtask

  // driver side of the scoreboard: queue one expectation, let monitor take it
  task automatic expect_out(input string r, input logic [5:0] e);
    rid_q.push_back(r);
    exp_q.push_back(e);
    tick(1);
  endtask

  task automatic check_int(input string r, input int act, input int exp);
    ntests++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d", r, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] arm, input logic fb, input logic ret,
                    input logic cs, input logic ci);
    cfg_arm = arm; cfg_fb_hs = fb; cfg_ret_main = ret;
    cfg_clr_stop = cs; cfg_clr_irq = ci; cfg_we = 1'b1;
    tick(1);
    cfg_we = 1'b0; cfg_ret_main = 1'b0; cfg_clr_stop = 1'b0; cfg_clr_irq = 1'b0;
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_ref);
    ntests++; nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  // expected vector order: sel, hs, stop, losc, irq, cause
  initial begin
    tick(6);
    rst = 1'b0;
    tick(1);
    expect_out("R11 reset state", 6'b000000);
    main_run = 1'b0; tick(40);
    expect_out("R11 R1 arm field 00 after reset", 6'b000000);
    main_run = 1'b1; tick(40);

    wr(2'b10, 1'b0, 1'b0, 1'b0, 1'b0);
    main_run = 1'b0; tick(40);
    expect_out("R1 code 10 disarmed", 6'b000000);
    main_run = 1'b1; tick(40);

    wr(2'b11, 1'b0, 1'b0, 1'b0, 1'b0);
    tick(300);
    expect_out("R9 running clock armed", 6'b000000);

    main_run = 1'b0; tick(40);
    expect_out("R2 R4 R5 failover low-speed", 6'b101111);
    wr(2'b11, 1'b0, 1'b1, 1'b0, 1'b0);
    expect_out("R6 return ignored while dead", 6'b101111);
    wr(2'b11, 1'b0, 1'b0, 1'b1, 1'b1);
    tick(40);
    expect_out("R8 no re-trigger on-chip", 6'b100100);
    main_run = 1'b1; tick(40);
    expect_out("R6 no auto return", 6'b100100);
    wr(2'b11, 1'b0, 1'b1, 1'b0, 1'b0);
    expect_out("R6 R4 return accepted", 6'b000000);

    wr(2'b11, 1'b1, 1'b0, 1'b0, 1'b0);
    expect_out("R7 fallback high written", 6'b010000);
    main_run = 1'b0; tick(40);
    expect_out("R7 R2 failover high-speed", 6'b111111);
    wr(2'b11, 1'b1, 1'b0, 1'b0, 1'b1);
    expect_out("R3 R5 irq cleared stop kept", 6'b111100);
    wr(2'b11, 1'b1, 1'b0, 1'b1, 1'b0);
    expect_out("R3 stop cleared", 6'b110100);
    main_run = 1'b1; tick(40);
    wr(2'b11, 1'b1, 1'b1, 1'b0, 1'b0);
    expect_out("R6 return with high select", 6'b010000);

    // same-cycle failover and clear: strobe held with clear-irq every cycle
    cfg_arm = 2'b11; cfg_fb_hs = 1'b1; cfg_clr_irq = 1'b1; cfg_we = 1'b1;
    irq_hi = 0; win_on = 1'b1;
    main_run = 1'b0;
    tick(40);
    win_on = 1'b0; cfg_we = 1'b0; cfg_clr_irq = 1'b0;
    check_int("R10 irq high cycles", irq_hi, 1);
    expect_out("R10 stop kept after race", 6'b111100);

    rst = 1'b1; tick(3); rst = 1'b0; tick(1);
    expect_out("R11 mid-run reset", 6'b000000);
    tick(40);
    expect_out("R11 dead clock ignored after reset", 6'b000000);
    wr(2'b11, 1'b0, 1'b0, 1'b0, 1'b0);
    tick(3);
    expect_out("R1 arming with dead clock", 6'b101111);

    tick(2);
    finish_run();
  end
endmodule